// File: doc/BRIEF.md
# Configurable Macrocell Storage and Control Stage

This block is the register half of one programmable-logic cell. The combinational part of the cell sits upstream and delivers an XOR result plus a set of single-bit product terms. This block turns those into a stored bit, a pin drive and a feedback signal. One storage element can act as a D, T, JK or SR flip-flop, or as a level-sensitive transparent latch. Static configuration pins set the behaviour of the cell.

Configuration pins select each control path separately. They pick the data source, the clock, whether a product-term clock enable applies, the asynchronous reset and preset sources, whether the pin sees the stored or the combinational value, the same choice for the feedback path, and the source of the output enable. Every pin is a plain level. No stream passes through the block, so it has no valid/ready handshake and no back-pressure. The configuration is treated as static and is changed only while the selected clock is low.

Top module: `macrocell_reg`

## Requirements
- R1: `cfg_dsel` picks the register data: 0 = `xor_in`, 1 = `pt_data`, 2 = `pin_in`, 3 = `xor_in`. The inputs that are not selected have no effect on the stored bit.
- R2: With `cfg_mode` 0 (D) the stored bit takes the data on a clock edge. With `cfg_mode` 1 (T) it inverts when the data is 1 and holds when the data is 0.
- R3: With `cfg_mode` 2 (JK), J comes from `pt_j` and K from `pt_k`. J=1,K=0 sets; J=0,K=1 clears; both 1 inverts; both 0 holds. The selected data is ignored.
- R4: With `cfg_mode` 3 (SR), S comes from `pt_j` and R from `pt_k`. S alone sets and R alone clears. S=R=0 and S=R=1 both hold the current state.
- R5: With `cfg_mode` 4 (latch), the stored value follows the selected data while the selected clock is high. It keeps the value present at the falling edge while the clock is low. The clock enable has no effect in this mode.
- R6: `cfg_csel` values 0..2 select `gclk[0..2]` and 3 selects `pt_clk`. Only a rising edge of the selected clock updates the register. Edges on any other clock are ignored, and so is a falling edge of the selected clock.
- R7: When `cfg_ce_en`=1 and a global clock is selected, an edge that arrives while `pt_ce`=0 is ignored. When `pt_clk` is selected, `pt_ce` has no effect.
- R8: `cfg_ar_sel` picks the asynchronous reset: 0 = none, 1 = `gclr`, 2 = `pt_ar`, 3 = either one. An active reset clears the stored bit at once, with no clock edge.
- R9: When `cfg_ap_en`=1, `pt_ap`=1 sets the stored bit at once. When `cfg_ap_en`=0, `pt_ap` is ignored. If reset and preset are active together, the bit is 0.
- R10: `cfg_out_reg`=1 drives `pin_out` from the stored bit. `cfg_out_reg`=0 drives it from `xor_in`.
- R11: `cfg_fb_reg` makes the same choice for `fb_out` (1 = stored bit, 0 = `xor_in`), independently of `cfg_out_reg`.
- R12: `cfg_oe_sel` picks `pin_oe`: 0 = 1, 1 = 0, 2 = `oe_pin[0]`, 3 = `oe_pin[1]`, 4 = `pt_oe`, 5..7 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 3 | Global clocks |
| gclr | input | 1 | Global clear |
| oe_pin | input | 2 | Dedicated output-enable pins |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_dsel | input | 2 | Data source select |
| cfg_csel | input | 2 | Clock source select |
| cfg_ce_en | input | 1 | Enable the product-term clock enable |
| cfg_ar_sel | input | 2 | Asynchronous reset source |
| cfg_ap_en | input | 1 | Enable the product-term preset |
| cfg_out_reg | input | 1 | Pin output registered (1) or combinational (0) |
| cfg_fb_reg | input | 1 | Feedback registered (1) or combinational (0) |
| cfg_oe_sel | input | 3 | Output-enable source |
| xor_in | input | 1 | XOR result from the logic array |
| pt_data | input | 1 | Spare product term used as data |
| pin_in | input | 1 | Value read from the I/O pin |
| pt_j | input | 1 | J / S product term |
| pt_k | input | 1 | K / R product term |
| pt_clk | input | 1 | Product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| pt_ar | input | 1 | Product-term asynchronous reset |
| pt_ap | input | 1 | Product-term asynchronous preset |
| pt_oe | input | 1 | Product-term output enable |
| pin_out | output | 1 | Pin drive value |
| fb_out | output | 1 | Feedback to the routing fabric |
| pin_oe | output | 1 | Pin output enable |

## Verification
Each test drives the unselected data inputs and clocks to the value opposite the expected result. A design with a swapped data or clock mux therefore loads a wrong bit, and a design that reacts to a non-selected clock, or to a falling edge, shows a visible change. Reset and preset are raised with no clock edge, which catches a design that handles them only synchronously. Applying both together catches a preset that wins over reset. A design that gates a product-term clock with the clock enable fails to load. A latch that keeps following its data after the falling edge shows the later value instead of the held one. The output and feedback selects are set to opposite choices so that a swapped or shared select can be seen.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    MD_D     = 3'd0,
    MD_T     = 3'd1,
    MD_JK    = 3'd2,
    MD_SR    = 3'd3,
    MD_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    DS_XOR  = 2'd0,
    DS_PT   = 2'd1,
    DS_PIN  = 2'd2,
    DS_XOR2 = 2'd3
  } dsel_e;

  typedef enum logic [1:0] {
    AR_NONE = 2'd0,
    AR_GLB  = 2'd1,
    AR_PT   = 2'd2,
    AR_ANY  = 2'd3
  } arsel_e;

  localparam int OE_FIXED = 2;

endpackage

// File: rtl/mc_ctrl_mux.sv
module mc_ctrl_mux #(
  parameter int N_GCLK = 3,
  localparam int CSW = $clog2(N_GCLK + 1)
) (
  input  logic [1:0]        cfg_dsel,
  input  logic [CSW-1:0]    cfg_csel,
  input  logic              cfg_ce_en,
  input  logic [1:0]        cfg_ar_sel,
  input  logic              cfg_ap_en,
  input  logic              xor_in,
  input  logic              pt_data,
  input  logic              pin_in,
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic              pt_ce,
  input  logic              gclr,
  input  logic              pt_ar,
  input  logic              pt_ap,
  output logic              d_sel,
  output logic              clk_eff,
  output logic              ce_ok,
  output logic              ar,
  output logic              ap
);
  import mc_pkg::*;

  logic glb_clk_sel;

  always_comb begin
    case (dsel_e'(cfg_dsel))
      DS_PT:   d_sel = pt_data;
      DS_PIN:  d_sel = pin_in;
      default: d_sel = xor_in;
    endcase
  end

  always_comb begin
    clk_eff = pt_clk;
    for (int i = 0; i < N_GCLK; i++) begin
      if (cfg_csel == CSW'(i)) clk_eff = gclk[i];
    end
  end

  assign glb_clk_sel = (cfg_csel < CSW'(N_GCLK));
  assign ce_ok       = !(cfg_ce_en && glb_clk_sel) || pt_ce;

  always_comb begin
    case (arsel_e'(cfg_ar_sel))
      AR_GLB:  ar = gclr;
      AR_PT:   ar = pt_ar;
      AR_ANY:  ar = gclr | pt_ar;
      default: ar = 1'b0;
    endcase
  end

  assign ap = cfg_ap_en & pt_ap;

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  mc_pkg::mode_e mode,
  input  logic          clk_eff,
  input  logic          ce_ok,
  input  logic          ar,
  input  logic          ap,
  input  logic          d,
  input  logic          j,
  input  logic          k,
  output logic          q
);
  import mc_pkg::*;

  logic ff_q;
  logic lat_q;
  logic nxt;
  logic lat_out;

  always_comb begin
    case (mode)
      MD_T:  nxt = ff_q ^ d;
      MD_JK: begin
        case ({j, k})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~ff_q;
          default: nxt = ff_q;
        endcase
      end
      MD_SR: begin
        case ({j, k})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = ff_q;
        endcase
      end
      MD_LATCH: nxt = ff_q;
      default:  nxt = d;
    endcase
  end

  // edge-triggered path; reset is tested first so it dominates preset
  always_ff @(posedge clk_eff or posedge ar or posedge ap) begin
    if (ar)         ff_q <= 1'b0;
    else if (ap)    ff_q <= 1'b1;
    else if (ce_ok) ff_q <= nxt;
  end

  // latch path: value captured as the clock falls, data passed while high
  always_ff @(negedge clk_eff or posedge ar or posedge ap) begin
    if (ar)      lat_q <= 1'b0;
    else if (ap) lat_q <= 1'b1;
    else         lat_q <= d;
  end

  always_comb begin
    if (ar)           lat_out = 1'b0;
    else if (ap)      lat_out = 1'b1;
    else if (clk_eff) lat_out = d;
    else              lat_out = lat_q;
  end

  assign q = (mode == MD_LATCH) ? lat_out : ff_q;

endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel #(
  parameter int N_OE = 2,
  localparam int OSW = $clog2(N_OE + 3)
) (
  input  logic            cfg_out_reg,
  input  logic            cfg_fb_reg,
  input  logic [OSW-1:0]  cfg_oe_sel,
  input  logic            q,
  input  logic            xor_in,
  input  logic [N_OE-1:0] oe_pin,
  input  logic            pt_oe,
  output logic            pin_out,
  output logic            fb_out,
  output logic            pin_oe
);
  import mc_pkg::*;

  assign pin_out = cfg_out_reg ? q : xor_in;
  assign fb_out  = cfg_fb_reg  ? q : xor_in;

  always_comb begin
    pin_oe = 1'b0;
    if (cfg_oe_sel == OSW'(0)) pin_oe = 1'b1;
    for (int i = 0; i < N_OE; i++) begin
      if (cfg_oe_sel == OSW'(OE_FIXED + i)) pin_oe = oe_pin[i];
    end
    if (cfg_oe_sel == OSW'(OE_FIXED + N_OE)) pin_oe = pt_oe;
  end

endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg #(
  parameter int N_GCLK = 3,
  parameter int N_OE   = 2,
  localparam int CSW = $clog2(N_GCLK + 1),
  localparam int OSW = $clog2(N_OE + 3)
) (
  input  logic [N_GCLK-1:0] gclk,
  input  logic              gclr,
  input  logic [N_OE-1:0]   oe_pin,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_dsel,
  input  logic [CSW-1:0]    cfg_csel,
  input  logic              cfg_ce_en,
  input  logic [1:0]        cfg_ar_sel,
  input  logic              cfg_ap_en,
  input  logic              cfg_out_reg,
  input  logic              cfg_fb_reg,
  input  logic [OSW-1:0]    cfg_oe_sel,
  input  logic              xor_in,
  input  logic              pt_data,
  input  logic              pin_in,
  input  logic              pt_j,
  input  logic              pt_k,
  input  logic              pt_clk,
  input  logic              pt_ce,
  input  logic              pt_ar,
  input  logic              pt_ap,
  input  logic              pt_oe,
  output logic              pin_out,
  output logic              fb_out,
  output logic              pin_oe
);
  import mc_pkg::*;

  logic d_sel, clk_eff, ce_ok, ar, ap, reg_q;

  mc_ctrl_mux #(.N_GCLK(N_GCLK)) u_ctrl (
    .cfg_dsel   (cfg_dsel),
    .cfg_csel   (cfg_csel),
    .cfg_ce_en  (cfg_ce_en),
    .cfg_ar_sel (cfg_ar_sel),
    .cfg_ap_en  (cfg_ap_en),
    .xor_in     (xor_in),
    .pt_data    (pt_data),
    .pin_in     (pin_in),
    .gclk       (gclk),
    .pt_clk     (pt_clk),
    .pt_ce      (pt_ce),
    .gclr       (gclr),
    .pt_ar      (pt_ar),
    .pt_ap      (pt_ap),
    .d_sel      (d_sel),
    .clk_eff    (clk_eff),
    .ce_ok      (ce_ok),
    .ar         (ar),
    .ap         (ap)
  );

  mc_store u_store (
    .mode    (mode_e'(cfg_mode)),
    .clk_eff (clk_eff),
    .ce_ok   (ce_ok),
    .ar      (ar),
    .ap      (ap),
    .d       (d_sel),
    .j       (pt_j),
    .k       (pt_k),
    .q       (reg_q)
  );

  mc_out_sel #(.N_OE(N_OE)) u_out (
    .cfg_out_reg (cfg_out_reg),
    .cfg_fb_reg  (cfg_fb_reg),
    .cfg_oe_sel  (cfg_oe_sel),
    .q           (reg_q),
    .xor_in      (xor_in),
    .oe_pin      (oe_pin),
    .pt_oe       (pt_oe),
    .pin_out     (pin_out),
    .fb_out      (fb_out),
    .pin_oe      (pin_oe)
  );

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
  parameter int N_OE = 2,
  localparam int OSW = $clog2(N_OE + 3)
) (
  input logic           clk_smp,
  input logic           gclr,
  input logic           pt_ar,
  input logic           pt_ap,
  input logic [1:0]     cfg_ar_sel,
  input logic           cfg_ap_en,
  input logic           cfg_out_reg,
  input logic           cfg_fb_reg,
  input logic [OSW-1:0] cfg_oe_sel,
  input logic           xor_in,
  input logic           pin_out,
  input logic           fb_out,
  input logic           pin_oe,
  input logic           reg_q
);

  logic pt_reset_on;
  assign pt_reset_on = cfg_ar_sel[1] & pt_ar;

  AST_PT_RESET_CLEARS: assert property (@(posedge clk_smp) disable iff (gclr)
    pt_reset_on |-> !reg_q); // R8

  AST_PRESET_SETS: assert property (@(posedge clk_smp) disable iff (gclr)
    (cfg_ap_en && pt_ap && !pt_reset_on) |-> reg_q); // R9

  AST_COMB_PIN: assert property (@(posedge clk_smp) disable iff (gclr)
    !cfg_out_reg |-> (pin_out == xor_in)); // R10

  AST_FB_TRACKS_PIN: assert property (@(posedge clk_smp) disable iff (gclr)
    (cfg_out_reg && cfg_fb_reg) |-> (pin_out == fb_out)); // R11

  AST_OE_FORCED_OFF: assert property (@(posedge clk_smp) disable iff (gclr)
    (cfg_oe_sel == OSW'(1)) |-> !pin_oe); // R12

endmodule

bind macrocell_reg mcr_checker #(.N_OE(N_OE)) u_mcr_checker (
  .clk_smp     (gclk[0]),
  .gclr        (gclr),
  .pt_ar       (pt_ar),
  .pt_ap       (pt_ap),
  .cfg_ar_sel  (cfg_ar_sel),
  .cfg_ap_en   (cfg_ap_en),
  .cfg_out_reg (cfg_out_reg),
  .cfg_fb_reg  (cfg_fb_reg),
  .cfg_oe_sel  (cfg_oe_sel),
  .xor_in      (xor_in),
  .pin_out     (pin_out),
  .fb_out      (fb_out),
  .pin_oe      (pin_oe),
  .reg_q       (reg_q)
);

// File: tb/test_macrocell_reg.sv
`timescale 1ns/1ps
module test_macrocell_reg;

  logic tb_clk = 1'b0;
  always #4 tb_clk = ~tb_clk;

  logic [2:0] gclk = '0;
  logic gclr = 1'b1;
  logic [1:0] oe_pin = '0;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_dsel = 2'd0;
  logic [1:0] cfg_csel = 2'd0;
  logic cfg_ce_en = 1'b0;
  logic [1:0] cfg_ar_sel = 2'd1;
  logic cfg_ap_en = 1'b0;
  logic cfg_out_reg = 1'b1;
  logic cfg_fb_reg = 1'b1;
  logic [2:0] cfg_oe_sel = 3'd0;
  logic xor_in = 0, pt_data = 0, pin_in = 0, pt_j = 0, pt_k = 0;
  logic pt_clk = 0, pt_ce = 0, pt_ar = 0, pt_ap = 0, pt_oe = 0;
  logic pin_out, fb_out, pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  macrocell_reg i_macrocell_reg (
    .gclk(gclk), .gclr(gclr), .oe_pin(oe_pin),
    .cfg_mode(cfg_mode), .cfg_dsel(cfg_dsel), .cfg_csel(cfg_csel),
    .cfg_ce_en(cfg_ce_en), .cfg_ar_sel(cfg_ar_sel), .cfg_ap_en(cfg_ap_en),
    .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg), .cfg_oe_sel(cfg_oe_sel),
    .xor_in(xor_in), .pt_data(pt_data), .pin_in(pin_in), .pt_j(pt_j), .pt_k(pt_k),
    .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_ar(pt_ar), .pt_ap(pt_ap), .pt_oe(pt_oe),
    .pin_out(pin_out), .fb_out(fb_out), .pin_oe(pin_oe)
  );

  // {mode[10:8], dsel[7:6], xor[5], pt_data[4], pin[3], j[2], k[1], expected q[0]}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drv;   // wait for the next falling edge of the bench clock
    @(negedge tb_clk);
  endtask

  task automatic smp;   // sample at the next rising edge, away from changes
    @(posedge tb_clk);
  endtask

  task automatic pulse_g(input int idx);
    drv(); gclk[idx] = 1'b1;
    drv(); gclk[idx] = 1'b0;
    smp();
  endtask

  task automatic pulse_pt;
    drv(); pt_clk = 1'b1;
    drv(); pt_clk = 1'b0;
    smp();
  endtask

  task automatic load(input logic v);
    drv(); cfg_mode = 3'd0; cfg_dsel = 2'd0; cfg_csel = 2'd0; xor_in = v;
    pulse_g(0);
  endtask

  always @(posedge tb_clk) begin
    static int cyc = 0;
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    smp();
    chk("R8 reset pin_out", pin_out, 1'b0);
    chk("R8 reset fb_out", fb_out, 1'b0);
    chk("R12 reset oe on", pin_oe, 1'b1);
    drv(); gclr = 1'b0;

    // table walk: one global clock edge per vector
    for (int v = 0; v < NV; v++) begin
      drv();
      cfg_mode = VEC[v][10:8]; cfg_dsel = VEC[v][7:6];
      xor_in = VEC[v][5]; pt_data = VEC[v][4]; pin_in = VEC[v][3];
      pt_j = VEC[v][2]; pt_k = VEC[v][1];
      pulse_g(0);
      case (VEC[v][10:8])
        3'd0:    chk("R1 D load", pin_out, VEC[v][0]);
        3'd1:    chk("R2 T toggle", pin_out, VEC[v][0]);
        3'd2:    chk("R3 JK", pin_out, VEC[v][0]);
        default: chk("R4 SR", pin_out, VEC[v][0]);
      endcase
    end
    drv(); pt_j = 0; pt_k = 0; pt_data = 0; pin_in = 0;

    // R6 clock source select
    load(1'b0);
    drv(); cfg_csel = 2'd1; xor_in = 1'b1;
    pulse_g(0); chk("R6 gclk0 ignored", pin_out, 1'b0);
    pulse_g(2); chk("R6 gclk2 ignored", pin_out, 1'b0);
    pulse_g(1); chk("R6 gclk1 loads", pin_out, 1'b1);
    drv(); cfg_csel = 2'd3; xor_in = 1'b0;
    pulse_g(1); chk("R6 gclk1 ignored under pt clock", pin_out, 1'b1);
    pulse_pt(); chk("R6 pt clock loads", pin_out, 1'b0);
    drv(); cfg_csel = 2'd0; xor_in = 1'b1; gclk[0] = 1'b1;
    smp(); chk("R6 rising edge loads", pin_out, 1'b1);
    drv(); xor_in = 1'b0;
    smp(); chk("R6 high level no load", pin_out, 1'b1);
    drv(); gclk[0] = 1'b0;
    smp(); chk("R6 falling edge no load", pin_out, 1'b1);

    // R7 clock enable
    drv(); cfg_ce_en = 1'b1; pt_ce = 1'b0; xor_in = 1'b0;
    pulse_g(0); chk("R7 edge ignored when ce low", pin_out, 1'b1);
    drv(); pt_ce = 1'b1;
    pulse_g(0); chk("R7 edge taken when ce high", pin_out, 1'b0);
    drv(); cfg_csel = 2'd3; pt_ce = 1'b0; xor_in = 1'b1;
    pulse_pt(); chk("R7 ce ignored with pt clock", pin_out, 1'b1);
    drv(); cfg_ce_en = 1'b0; cfg_csel = 2'd0;

    // R8 asynchronous reset selection
    load(1'b1);
    drv(); cfg_ar_sel = 2'd2; gclr = 1'b1;
    smp(); chk("R8 gclr ignored in pt mode", pin_out, 1'b1);
    drv(); gclr = 1'b0; pt_ar = 1'b1;
    smp(); chk("R8 pt reset clears without clock", pin_out, 1'b0);
    drv(); pt_ar = 1'b0;
    load(1'b1);
    drv(); cfg_ar_sel = 2'd1; pt_ar = 1'b1;
    smp(); chk("R8 pt reset ignored in global mode", pin_out, 1'b1);
    drv(); pt_ar = 1'b0; gclr = 1'b1;
    smp(); chk("R8 gclr clears", pin_out, 1'b0);
    drv(); gclr = 1'b0; cfg_ar_sel = 2'd3;
    load(1'b1);
    drv(); pt_ar = 1'b1;
    smp(); chk("R8 OR mode pt clears", pin_out, 1'b0);
    drv(); pt_ar = 1'b0;
    load(1'b1);
    drv(); gclr = 1'b1;
    smp(); chk("R8 OR mode gclr clears", pin_out, 1'b0);
    drv(); gclr = 1'b0; cfg_ar_sel = 2'd0;
    load(1'b1);
    drv(); gclr = 1'b1; pt_ar = 1'b1;
    smp(); chk("R8 reset off ignores both", pin_out, 1'b1);
    drv(); gclr = 1'b0; pt_ar = 1'b0; cfg_ar_sel = 2'd2;

    // R9 preset and priority
    load(1'b0);
    drv(); pt_ap = 1'b1;
    smp(); chk("R9 preset disabled", pin_out, 1'b0);
    drv(); pt_ap = 1'b0; cfg_ap_en = 1'b1;
    drv(); pt_ap = 1'b1;
    smp(); chk("R9 preset sets without clock", pin_out, 1'b1);
    drv(); pt_ap = 1'b0;
    load(1'b0);
    drv(); pt_ap = 1'b1; pt_ar = 1'b1;
    smp(); chk("R9 reset wins over preset", pin_out, 1'b0);
    drv(); pt_ap = 1'b0; pt_ar = 1'b0; cfg_ap_en = 1'b0;

    // R10 / R11 output and feedback selects
    load(1'b1);
    drv(); cfg_out_reg = 1'b0; cfg_fb_reg = 1'b1; xor_in = 1'b0;
    smp(); chk("R10 comb pin", pin_out, 1'b0);
    chk("R11 reg feedback", fb_out, 1'b1);
    drv(); xor_in = 1'b1;
    smp(); chk("R10 comb pin follows", pin_out, 1'b1);
    drv(); cfg_out_reg = 1'b1; cfg_fb_reg = 1'b0; xor_in = 1'b0;
    smp(); chk("R10 reg pin", pin_out, 1'b1);
    chk("R11 comb feedback", fb_out, 1'b0);
    drv(); cfg_fb_reg = 1'b1;

    // R12 output enable
    drv(); oe_pin = 2'b01; pt_oe = 1'b0; cfg_oe_sel = 3'd0;
    smp(); chk("R12 always on", pin_oe, 1'b1);
    drv(); cfg_oe_sel = 3'd1;
    smp(); chk("R12 always off", pin_oe, 1'b0);
    drv(); cfg_oe_sel = 3'd2;
    smp(); chk("R12 oe pin 0", pin_oe, 1'b1);
    drv(); cfg_oe_sel = 3'd3;
    smp(); chk("R12 oe pin 1 low", pin_oe, 1'b0);
    drv(); oe_pin = 2'b10;
    smp(); chk("R12 oe pin 1 high", pin_oe, 1'b1);
    drv(); cfg_oe_sel = 3'd2;
    smp(); chk("R12 oe pin 0 low", pin_oe, 1'b0);
    drv(); cfg_oe_sel = 3'd4;
    smp(); chk("R12 pt oe low", pin_oe, 1'b0);
    drv(); pt_oe = 1'b1;
    smp(); chk("R12 pt oe high", pin_oe, 1'b1);
    drv(); cfg_oe_sel = 3'd5;
    smp(); chk("R12 unused code off", pin_oe, 1'b0);
    drv(); cfg_oe_sel = 3'd0;

    // R5 latch mode
    drv(); cfg_ar_sel = 2'd1; gclr = 1'b1;
    drv(); gclr = 1'b0; cfg_mode = 3'd4; cfg_csel = 2'd0;
    cfg_ce_en = 1'b1; pt_ce = 1'b0; xor_in = 1'b0;
    smp(); chk("R5 latch held after clear", pin_out, 1'b0);
    drv(); gclk[0] = 1'b1; xor_in = 1'b1;
    smp(); chk("R5 transparent high, ce ignored", pin_out, 1'b1);
    drv(); xor_in = 1'b0;
    smp(); chk("R5 transparent follows", pin_out, 1'b0);
    drv(); xor_in = 1'b1;
    drv(); gclk[0] = 1'b0;
    drv(); xor_in = 1'b0;
    smp(); chk("R5 holds while low", pin_out, 1'b1);
    drv(); cfg_ce_en = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule